// File: doc/BRIEF.md
# Vectored Interrupt Controller with Masking

This block gathers a set of level-sensitive interrupt request lines (32 by default) and forwards them as one interrupt line to a parent controller. Each line has its own mask bit and a 4-bit priority. Software programs the block through a small register bus with a 9-bit byte address and a 16-bit write port. The 32-bit read port returns data one cycle after a read strobe.

Every 8-bit mask register can be reached at two addresses. A write to the set address masks the sources whose bits are 1. A write to the clear address, 0x40 higher, unmasks them. Priorities sit four to a 16-bit register. Some sources form a group and share one priority field, but each member keeps its own mask bit. A source whose priority is zero never reaches the parent.

Among the eligible requests, the block picks the one with the highest priority. The parent reads that request's event code from a read-only register, and the code tells the parent which source to service.

Top module: `vic_top`

## Requirements
- R1: After reset every mask bit is 1 (masked), every priority field is 0, `irq_o` is low and the event-code register reads 0.
- R2: A write to mask-set address 0x184+4k sets mask bit j of register k (source 8k+j) for every 1 in `wdata_i[7:0]`. Bits written as 0 are unchanged. A read of this address returns the register in bits 7:0.
- R3: A write to mask-clear address 0x1C4+4k clears mask bit j of register k for every 1 in `wdata_i[7:0]`. Bits written as 0 are unchanged. A read returns the same register as R2.
- R4: Priority register r sits at address 4r (r = 0..6). It holds fields 4r..4r+3, with field 4r+i in bits 4i+3:4i. A write stores `wdata_i[15:0]`, and a read returns it zero-extended.
- R5: Source s takes its priority from field s for s<16. Sources 16..19 share field 16, sources 20..23 share field 17, and source s in 24..31 uses field s-6.
- R6: A source is eligible only when its request is high, its mask bit is 0 and its priority is non-zero. A zero priority blocks it even when it is requesting and unmasked.
- R7: `irq_o` is high exactly one clock edge after some source is eligible, and low otherwise.
- R8: The selected source has the highest priority value. When priorities tie, the lowest source index wins.
- R9: A read of address 0x100 returns 0x400 + 0x20·s, where s is the selected source. It returns 0 when no source is eligible. The register is read-only.
- R10: Read data is updated on the edge that samples `rd_en_i` and holds otherwise. Unmapped addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req_i | input | NUM_SRC | Level request lines, one per source |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address in the register window |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | Combined interrupt to the parent controller |

## Verification
A register write takes effect on the clock edge that samples it. The selection reacts to that new state and to any request change, and it reaches `irq_o` and the event-code register one edge later. Read data appears one edge after the read strobe. The bench therefore drives on the falling edge and lets at least one full rising edge pass after the last write or request change before it samples `irq_o`. It then issues a read and compares `rdata_o` at the next falling edge, so every compare lands in the cycle in which its result is due.

// File: rtl/vic_pkg.sv
// vic_pkg: shared constants, the candidate record passed from selection
// to output stage, and the source-to-priority-field grouping.
// Assumes a 4-bit priority and at most 256 sources.
package vic_pkg;
    localparam int unsigned PRIO_W     = 4;
    localparam int unsigned FLD_PER_RG = 4;
    localparam int unsigned IDX_W      = 8;
    localparam int unsigned PREG_W     = 16;
    localparam int unsigned RD_W       = 32;
    localparam int unsigned MASK_BASE  = 'h184;
    localparam int unsigned CLR_OFS    = 'h40;
    localparam int unsigned EVT_ADDR   = 'h100;

    typedef struct packed {
        logic              vld;
        logic [PRIO_W-1:0] prio;
        logic [IDX_W-1:0]  idx;
    } cand_t;

    // Grouping (R5): shared fields for sources 16..19 and 20..23.
    function automatic int unsigned field_of(input int unsigned s);
        if (s < 16)      return s;
        else if (s < 20) return 16;
        else if (s < 24) return 17;
        else             return s - 6;
    endfunction

    function automatic int unsigned num_fields(input int unsigned n);
        return field_of(n - 1) + 1;
    endfunction
endpackage

// File: rtl/vic_regs.sv
// vic_regs: mask registers (set and clear addresses) and packed priority
// registers, plus the registered read-back mux.
// Assumes word-aligned addresses; writes take one edge, reads answer
// one edge after rd_en.
module vic_regs
    import vic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 9,
    localparam int unsigned NUM_MREG = (NUM_SRC + 7) / 8,
    localparam int unsigned NUM_FLD  = num_fields(NUM_SRC),
    localparam int unsigned NUM_PREG = (NUM_FLD + FLD_PER_RG - 1) / FLD_PER_RG
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [PREG_W-1:0]         wdata,
    input  logic [15:0]               evt_code,
    output logic [RD_W-1:0]           rdata,
    output logic [NUM_SRC-1:0]        mask_o,
    output logic [NUM_FLD*PRIO_W-1:0] fields_o
);
    logic [NUM_MREG*8-1:0]      mask_q;
    logic [NUM_PREG*PREG_W-1:0] prio_q;
    logic [RD_W-1:0]            rd_mux;

    for (genvar k = 0; k < NUM_MREG; k++) begin : g_mask
        localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(MASK_BASE + 4 * k);
        localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(MASK_BASE + CLR_OFS + 4 * k);
        // Mask register k: set on SET_A, clear on CLR_A (R2, R3).
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[k*8 +: 8] <= 8'hFF;
            else if (wr_en && addr == SET_A)
                mask_q[k*8 +: 8] <= mask_q[k*8 +: 8] | wdata[7:0];
            else if (wr_en && addr == CLR_A)
                mask_q[k*8 +: 8] <= mask_q[k*8 +: 8] & ~wdata[7:0];
        end
    end

    for (genvar r = 0; r < NUM_PREG; r++) begin : g_prio
        localparam logic [ADDR_W-1:0] PRIO_A = ADDR_W'(4 * r);
        // Priority register r: whole 16-bit write (R4).
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q[r*PREG_W +: PREG_W] <= '0;
            else if (wr_en && addr == PRIO_A)
                prio_q[r*PREG_W +: PREG_W] <= wdata;
        end
    end

    // Read-back decode; unmapped addresses give zero (R10).
    always_comb begin
        rd_mux = '0;
        if (addr == ADDR_W'(EVT_ADDR))
            rd_mux = RD_W'(evt_code);
        for (int k = 0; k < NUM_MREG; k++) begin
            if (addr == ADDR_W'(MASK_BASE + 4 * k) ||
                addr == ADDR_W'(MASK_BASE + CLR_OFS + 4 * k))
                rd_mux = RD_W'(mask_q[k*8 +: 8]);
        end
        for (int r = 0; r < NUM_PREG; r++) begin
            if (addr == ADDR_W'(4 * r))
                rd_mux = RD_W'(prio_q[r*PREG_W +: PREG_W]);
        end
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

    assign mask_o   = mask_q[NUM_SRC-1:0];
    assign fields_o = prio_q[NUM_FLD*PRIO_W-1:0];
endmodule

// File: rtl/vic_select.sv
// vic_select: combinational choice of the winning source.
// Eligible = requesting, unmasked, non-zero priority (R6); highest
// priority wins, lowest index on ties (R8). Assumes NUM_SRC <= 256.
module vic_select
    import vic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0]        req,
    input  logic [NUM_SRC-1:0]        mask,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    output cand_t                     best
);
    // Linear scan; strict compare keeps the lowest index on a tie.
    always_comb begin
        best = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (req[s] && !mask[s] && src_prio[s*PRIO_W +: PRIO_W] != '0 &&
                (!best.vld || src_prio[s*PRIO_W +: PRIO_W] > best.prio)) begin
                best.vld  = 1'b1;
                best.prio = src_prio[s*PRIO_W +: PRIO_W];
                best.idx  = IDX_W'(s);
            end
        end
    end
endmodule

// File: rtl/vic_out.sv
// vic_out: registers the selection into the parent interrupt line and
// the event code (R7, R9). Assumes the code fits 16 bits.
module vic_out
    import vic_pkg::*;
#(
    parameter int unsigned EVT_BASE = 'h400,
    parameter int unsigned EVT_STEP = 'h20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  cand_t       best,
    output logic        irq,
    output logic [15:0] code
);
    // One-edge output stage; zero code while nothing is eligible.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq  <= 1'b0;
            code <= '0;
        end else begin
            irq  <= best.vld;
            code <= best.vld ? 16'(EVT_BASE + int'(best.idx) * EVT_STEP) : 16'h0;
        end
    end
endmodule

// File: rtl/vic_top.sv
// vic_top: vectored interrupt controller with per-source masking and
// grouped 4-bit priorities. Maps each source to its priority field,
// selects a winner and drives one interrupt to the parent.
// Assumes level requests already synchronous to clk.
module vic_top
    import vic_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned ADDR_W   = 9,
    parameter int unsigned EVT_BASE = 'h400,
    parameter int unsigned EVT_STEP = 'h20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [15:0]        wdata_i,
    output logic [31:0]        rdata_o,
    output logic               irq_o
);
    localparam int unsigned NUM_FLD = num_fields(NUM_SRC);

    logic [NUM_SRC-1:0]        mask_bits;
    logic [NUM_FLD*PRIO_W-1:0] fields;
    logic [NUM_SRC*PRIO_W-1:0] src_prio;
    logic [15:0]               evt_code;
    cand_t                     best;

    vic_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_i),
        .rd_en    (rd_en_i),
        .addr     (addr_i),
        .wdata    (wdata_i),
        .evt_code (evt_code),
        .rdata    (rdata_o),
        .mask_o   (mask_bits),
        .fields_o (fields)
    );

    // Source-to-field routing (R5).
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_route
        localparam int unsigned FLD = field_of(s);
        assign src_prio[s*PRIO_W +: PRIO_W] = fields[FLD*PRIO_W +: PRIO_W];
    end

    vic_select #(.NUM_SRC(NUM_SRC)) u_select (
        .req      (irq_req_i),
        .mask     (mask_bits),
        .src_prio (src_prio),
        .best     (best)
    );

    vic_out #(.EVT_BASE(EVT_BASE), .EVT_STEP(EVT_STEP)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .best  (best),
        .irq   (irq_o),
        .code  (evt_code)
    );
endmodule

// File: rtl/vic_top_sva.sv
// vic_top_sva: temporal checks on vic_top, attached by bind.
module vic_top_sva #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [15:0]        wdata,
    input logic [31:0]        rdata,
    input logic [NUM_SRC-1:0] irq_req,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] mask
);
    localparam logic [ADDR_W-1:0] SET0 = ADDR_W'('h184);
    localparam logic [ADDR_W-1:0] CLR0 = ADDR_W'('h1C4);
    localparam logic [ADDR_W-1:0] EVTA = ADDR_W'('h100);
    localparam logic [ADDR_W-1:0] HOLE = ADDR_W'('h1FC);

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !irq_o);
    a_r7_no_request_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req == '0) |=> !irq_o);
    a_r6_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & ~mask) == '0) |=> !irq_o);
    a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SET0) |=> ((mask[7:0] & $past(wdata[7:0])) == $past(wdata[7:0])));
    a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CLR0) |=> ((mask[7:0] & $past(wdata[7:0])) == 8'h00));
    a_r9_idle_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == EVTA && !irq_o) |=> (rdata == 32'h0));
    a_r9_code_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == EVTA) |=> (rdata[4:0] == 5'h0));
    a_r10_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == HOLE) |=> (rdata == 32'h0));
endmodule

bind vic_top vic_top_sva #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_i),
    .rd_en   (rd_en_i),
    .addr    (addr_i),
    .wdata   (wdata_i),
    .rdata   (rdata_o),
    .irq_req (irq_req_i),
    .irq_o   (irq_o),
    .mask    (mask_bits)
);

// File: tb/vic_top_bench.sv
module vic_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_req = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [8:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] mask_m;
    logic [15:0] prio_m [7];

    always #(CLK_PERIOD/2) clk = ~clk;

    vic_top u_vic_top (
        .clk (clk), .rst_n (rst_n), .irq_req_i (irq_req),
        .wr_en_i (wr_en), .rd_en_i (rd_en), .addr_i (addr),
        .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq_o)
    );

    function automatic int fld(input int s);
        if (s < 16) return s;
        if (s < 20) return 16;
        if (s < 24) return 17;
        return s - 6;
    endfunction

    function automatic logic [3:0] prio_of(input int s);
        int f = fld(s);
        return prio_m[f/4][(f%4)*4 +: 4];
    endfunction

    function automatic int winner(input logic [31:0] req);
        int w = -1;
        logic [3:0] bp = '0;
        for (int s = 0; s < NSRC; s++)
            if (req[s] && !mask_m[s] && prio_of(s) != 0 && (w < 0 || prio_of(s) > bp)) begin
                w = s;
                bp = prio_of(s);
            end
        return w;
    endfunction

    function automatic logic [31:0] code_of(input int w);
        return (w < 0) ? 32'h0 : 32'(32'h400 + 32'h20 * w);
    endfunction

    function automatic logic [31:0] exp_read(input logic [8:0] a);
        int ai = int'(a);
        if (ai == 'h100) return code_of(winner(irq_req));
        if (ai[1:0] == 0 && ai >= 'h184 && ai < 'h194) return 32'(mask_m[(ai-'h184)/4*8 +: 8]);
        if (ai[1:0] == 0 && ai >= 'h1C4 && ai < 'h1D4) return 32'(mask_m[(ai-'h1C4)/4*8 +: 8]);
        if (ai[1:0] == 0 && ai < 28) return 32'(prio_m[ai/4]);
        return 32'h0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic do_write(input logic [8:0] a, input logic [15:0] d);
        int ai = int'(a);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (ai[1:0] == 0 && ai >= 'h184 && ai < 'h194)
            mask_m[(ai-'h184)/4*8 +: 8] = mask_m[(ai-'h184)/4*8 +: 8] | d[7:0];
        else if (ai[1:0] == 0 && ai >= 'h1C4 && ai < 'h1D4)
            mask_m[(ai-'h1C4)/4*8 +: 8] = mask_m[(ai-'h1C4)/4*8 +: 8] & ~d[7:0];
        else if (ai[1:0] == 0 && ai < 28)
            prio_m[ai/4] = d;
    endtask

    task automatic do_read(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    // Lets one rising edge pass, then checks irq_o and the event code.
    task automatic check_state(input string tag);
        logic [31:0] d;
        int w;
        @(negedge clk);
        w = winner(irq_req);
        chk(irq_o == (w >= 0), {tag, " R7 irq"}, 32'(irq_o), 32'(w >= 0));
        do_read(9'h100, d);
        chk(d == code_of(w), {tag, " R9 code"}, d, code_of(w));
    endtask

    task automatic check_read(input logic [8:0] a, input string tag);
        logic [31:0] d;
        logic [31:0] e;
        e = exp_read(a);
        do_read(a, d);
        chk(d == e, tag, d, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        mask_m = '1;
        for (int r = 0; r < 7; r++) prio_m[r] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk(irq_o == 1'b0, "R1 irq after reset", 32'(irq_o), 32'h0);
        for (int k = 0; k < 4; k++) check_read(9'(32'h184 + 4*k), "R1 mask reset");
        for (int r = 0; r < 7; r++) check_read(9'(4*r), "R1 prio reset");
        check_state("R1");

        // R6: unmasked, requesting, zero priority stays silent
        for (int k = 0; k < 4; k++) do_write(9'(32'h1C4 + 4*k), 16'h00FF);
        irq_req = '1;
        check_state("R6 zero prio");
        chk(irq_o == 1'b0, "R6 blocked", 32'(irq_o), 32'h0);

        // R4: field packing; source 5 uses bits 7:4 of register 1
        do_write(9'h004, 16'hA5C3);
        check_read(9'h004, "R4 readback");
        irq_req = 32'h0000_0020;
        check_state("R4 src5");
        check_read(9'h100, "R9 src5 code 0x4A0");

        // R8: tie goes to lower index; higher priority beats lower index
        do_write(9'h000, 16'h000C);
        irq_req = 32'h0000_0021;
        check_state("R8 tie");
        chk(exp_read(9'h100) == 32'h400, "R8 tie model", exp_read(9'h100), 32'h400);
        irq_req = 32'h0000_00C0;
        check_state("R8 higher index wins");

        // R5: group field 16 shared by sources 16..19
        do_write(9'h010, 16'h0007);
        irq_req = 32'h0006_0000;
        check_state("R5 group");
        do_write(9'h18C, 16'h0002);
        check_state("R5 R2 member masked");
        do_write(9'h18C, 16'h0000);
        check_read(9'h18C, "R2 zero bits no effect");
        do_write(9'h1CC, 16'h0000);
        check_read(9'h1CC, "R3 zero bits no effect");
        do_write(9'h1CC, 16'h0002);
        check_read(9'h18C, "R3 unmask read via set address");

        // R10: unmapped and read-only addresses
        check_read(9'h1FC, "R10 hole");
        check_read(9'h1D4, "R10 beyond masks");
        do_write(9'h100, 16'hFFFF);
        check_state("R10 evt write ignored");

        // Random mix
        for (int it = 0; it < 300; it++) begin
            int op = int'($urandom_range(0, 4));
            case (op)
                0: do_write(9'(32'h184 + 4*$urandom_range(0, 3)), 16'($urandom) & 16'h00FF & 16'($urandom));
                1: do_write(9'(32'h1C4 + 4*$urandom_range(0, 3)), 16'($urandom));
                2: do_write(9'(4*$urandom_range(0, 6)), 16'($urandom));
                3: do_write(9'($urandom) & 9'h1FC, 16'($urandom));
                default: irq_req = $urandom & $urandom;
            endcase
            if (op != 4 && ($urandom & 1) == 1) irq_req = $urandom & $urandom;
            check_state("R8 random");
            check_read(9'($urandom) & 9'h1FC, "R10 random readback");
        end

        finish_run();
    end
endmodule